// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block decides which interrupt request the core takes, and when it takes it. It watches five request lines. One line cannot be masked. Three restart lines each carry their own mask bit. The last line is a general request that needs an external acknowledge. The block also holds a global interrupt enable. Instruction strobes from the decoder set or clear that enable, and any accepted interrupt clears it at once.

Arbitration happens only on a clock where the core raises its next-to-last-clock strobe. On that clock the block picks the highest-ranked eligible request. One cycle later it reports the pick for exactly one cycle, in one of two ways:
- a fixed restart vector address, or
- a flag asking the bus unit to run an acknowledge cycle for the general request.

A set-mask strobe does two jobs: it loads the restart masks and it clears the edge-caught restart. A status byte gives software a view of the masks, the enable and the pending restart requests.

Top module: `prio_irq_ctl`

## Requirements
- R1: Ranking from highest to lowest is: non-maskable line, restart-A (7.5), restart-B (6.5), restart-C (5.5), then the general request. The vectors are 0x0024 for the non-maskable line, 0x003C for A, 0x0034 for B and 0x002C for C. `vec_o` reads 0x0000 when nothing is taken and when the general request is taken.
- R2: A pending non-maskable request is accepted whatever the enable and the mask bits hold.
- R3: A request is accepted only at a rising clock edge where `last_clk_i` is high. In the following cycle, and only in that cycle, `take_o` is high and `vec_o` / `ext_ack_o` describe the winner.
- R4: Accepting the general request raises `ext_ack_o` together with `take_o`, with `vec_o` at 0x0000. A restart or non-maskable acceptance leaves `ext_ack_o` low.
- R5: The global enable is low after reset.
  - Opcode 0xFB on `op_i`, with `op_vld_i` high, sets it. Opcode 0xF3 clears it.
  - Any acceptance clears it, and this wins over an enable opcode on the same edge.
  - The maskable lines (A, B, C and the general request) are accepted only while it is set.
- R6: A `msk_we_i` strobe with `msk_d_i[3]` high loads the masks from `msk_d_i[2:0]` (bit 2 = A, bit 1 = B, bit 0 = C). With bit 3 low, the masks are left unchanged. A set mask bit blocks its line. All masks are set by reset.
- R7: Restart-A is held by a rising-edge latch. The latch sets even while A is masked. It clears when A is accepted, or on a `msk_we_i` strobe with `msk_d_i[4]` high. An input that is merely held high does not set it again.
- R8: Restart-B and restart-C are level sensitive: they count only if the line is high at the sampling edge.
- R9: The non-maskable line is recognised only if it rose at an earlier clock edge and is still high at the sampling edge. After it is accepted, a new rise is needed.
- R10: `stat_o` layout:
  - bits 2:0: masks (A, B, C)
  - bit 3: global enable
  - bit 4: restart-C level
  - bit 5: restart-B level
  - bit 6: restart-A latch
  - bit 7: always 0

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request |
| rst75_i | input | 1 | Restart-A request (edge caught) |
| rst65_i | input | 1 | Restart-B request (level) |
| rst55_i | input | 1 | Restart-C request (level) |
| gen_req_i | input | 1 | General request needing external acknowledge |
| last_clk_i | input | 1 | Next-to-last clock of the current instruction |
| op_vld_i | input | 1 | Qualifies `op_i` |
| op_i | input | 8 | Opcode being executed |
| msk_we_i | input | 1 | Set-mask strobe |
| msk_d_i | input | 8 | Set-mask data |
| take_o | output | 1 | Interrupt accepted (one-cycle pulse) |
| ext_ack_o | output | 1 | Run an external acknowledge cycle |
| vec_o | output | 16 | Restart vector of the accepted request |
| stat_o | output | 8 | Status byte |

## Verification
The internal state is seen at the ports in two ways:
- Enable and mask state appears on `stat_o` in the same cycle it changes, so a wrong bit shows up one clock after the strobe that set it.
- The edge-catch state of the non-maskable line is not on `stat_o`. A fault there shows only at the next sampling edge, as a missing or extra `take_o` pulse one cycle later.

A wrong ranking shows as a wrong `vec_o`, or a wrong `ext_ack_o`, in the pulse that follows a sampling edge with several requests pending. The bench therefore holds several lines high at once. A reference model, restated in behavioural form, checks every port on every clock.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int NRST = 3;          // self-vectoring restart lines
  localparam int NSRC = NRST + 2;   // plus non-maskable and general

  // index 0 is the highest rank
  typedef enum logic [2:0] {
    SRC_NONE, SRC_NMI, SRC_RA, SRC_RB, SRC_RC, SRC_GEN
  } src_e;

  // keep only the lowest set bit (highest rank)
  function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] req);
    logic [NSRC-1:0] res;
    res = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        res = '0;
        res[i] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic src_e src_of(input logic [NSRC-1:0] win);
    src_e s;
    s = SRC_NONE;
    if (win[0]) s = SRC_NMI;
    else if (win[1]) s = SRC_RA;
    else if (win[2]) s = SRC_RB;
    else if (win[3]) s = SRC_RC;
    else if (win[4]) s = SRC_GEN;
    return s;
  endfunction
endpackage

// File: rtl/irc_edge_catch.sv
module irc_edge_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q;
  logic hold_q;
  logic rise_w;

  assign rise_w = lvl_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      hold_q <= (hold_q & ~clr_i) | rise_w;
    end
  end

  assign pend_o = hold_q;
endmodule

// File: rtl/irc_ctl_regs.sv
module irc_ctl_regs #(
  parameter int MW       = 3,
  parameter int OP_W     = 8,
  parameter int DW       = 8,
  parameter logic [OP_W-1:0] OP_EN  = 8'hFB,
  parameter logic [OP_W-1:0] OP_DIS = 8'hF3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic            op_vld_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            mw_i,
  input  logic [DW-1:0]   md_i,
  output logic            ien_o,
  output logic [MW-1:0]   mask_o
);
  localparam int LOAD_BIT = MW;

  logic ien_q;
  logic [MW-1:0] mask_q;
  logic en_hit, dis_hit;

  assign en_hit  = op_vld_i && (op_i == OP_EN);
  assign dis_hit = op_vld_i && (op_i == OP_DIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (accept_i)     ien_q <= 1'b0;
      else if (en_hit)  ien_q <= 1'b1;
      else if (dis_hit) ien_q <= 1'b0;
      if (mw_i && md_i[LOAD_BIT]) mask_q <= md_i[MW-1:0];
    end
  end

  assign ien_o  = ien_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter
  import irc_pkg::*;
(
  input  logic            nmi_pend_i,
  input  logic [NRST-1:0] rst_req_i,   // [NRST-1] is the highest restart
  input  logic [NRST-1:0] mask_i,
  input  logic            ien_i,
  input  logic            gen_i,
  output logic [NSRC-1:0] win_o
);
  logic [NSRC-1:0] elig_w;

  assign elig_w[0] = nmi_pend_i;
  for (genvar k = 0; k < NRST; k++) begin : g_rst
    assign elig_w[1+k] = rst_req_i[NRST-1-k] & ~mask_i[NRST-1-k] & ien_i;
  end
  assign elig_w[NSRC-1] = gen_i & ien_i;

  assign win_o = pick_first(elig_w);
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
  import irc_pkg::*;
#(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_NMI = 16'h0024,
  parameter logic [VW-1:0] VEC_RA  = 16'h003C,
  parameter logic [VW-1:0] VEC_RB  = 16'h0034,
  parameter logic [VW-1:0] VEC_RC  = 16'h002C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_i,
  input  logic          rst75_i,
  input  logic          rst65_i,
  input  logic          rst55_i,
  input  logic          gen_req_i,
  input  logic          last_clk_i,
  input  logic          op_vld_i,
  input  logic [7:0]    op_i,
  input  logic          msk_we_i,
  input  logic [7:0]    msk_d_i,
  output logic          take_o,
  output logic          ext_ack_o,
  output logic [VW-1:0] vec_o,
  output logic [7:0]    stat_o
);
  localparam int CLR_A_BIT = NRST + 1;

  logic            nmi_pend_w;
  logic            ra_pend_w;
  logic            nmi_clr_w;
  logic            ra_clr_w;
  logic            ien_w;
  logic [NRST-1:0] mask_w;
  logic [NSRC-1:0] win_w;
  logic            accept_w;
  logic [VW-1:0]   vec_sel_w;
  logic            take_q, ext_q;
  logic [VW-1:0]   vec_q;

  assign accept_w  = last_clk_i & (|win_w);
  assign nmi_clr_w = ~nmi_i | (accept_w & win_w[0]);
  assign ra_clr_w  = (msk_we_i & msk_d_i[CLR_A_BIT]) | (accept_w & win_w[1]);

  irc_edge_catch u_nmi (
    .clk(clk), .rst_n(rst_n), .lvl_i(nmi_i), .clr_i(nmi_clr_w), .pend_o(nmi_pend_w)
  );

  irc_edge_catch u_ra (
    .clk(clk), .rst_n(rst_n), .lvl_i(rst75_i), .clr_i(ra_clr_w), .pend_o(ra_pend_w)
  );

  irc_ctl_regs #(.MW(NRST), .OP_W(8), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_w),
    .op_vld_i(op_vld_i), .op_i(op_i),
    .mw_i(msk_we_i), .md_i(msk_d_i),
    .ien_o(ien_w), .mask_o(mask_w)
  );

  irc_arbiter u_arb (
    .nmi_pend_i(nmi_pend_w & nmi_i),
    .rst_req_i({ra_pend_w, rst65_i, rst55_i}),
    .mask_i(mask_w),
    .ien_i(ien_w),
    .gen_i(gen_req_i),
    .win_o(win_w)
  );

  always_comb begin
    case (src_of(win_w))
      SRC_NMI: vec_sel_w = VEC_NMI;
      SRC_RA:  vec_sel_w = VEC_RA;
      SRC_RB:  vec_sel_w = VEC_RB;
      SRC_RC:  vec_sel_w = VEC_RC;
      default: vec_sel_w = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      ext_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= accept_w;
      ext_q  <= accept_w & win_w[NSRC-1];
      vec_q  <= accept_w ? vec_sel_w : '0;
    end
  end

  assign take_o    = take_q;
  assign ext_ack_o = ext_q;
  assign vec_o     = vec_q;
  assign stat_o    = {1'b0, ra_pend_w, rst65_i, rst55_i, ien_w, mask_w};
endmodule

// File: rtl/prio_irq_ctl_chk.sv
module prio_irq_ctl_chk #(
  parameter int VW = 16,
  parameter logic [VW-1:0] VEC_NMI = 16'h0024
) (
  input logic          clk,
  input logic          rst_n,
  input logic          last_clk_i,
  input logic          nmi_i,
  input logic          nmi_pend_w,
  input logic          ien_w,
  input logic [4:0]    win_w,
  input logic          take_o,
  input logic          ext_ack_o,
  input logic [VW-1:0] vec_o
);
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_w)); // R1
  AST_NMI_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (last_clk_i && nmi_pend_w && nmi_i) |=> (take_o && vec_o == VEC_NMI)); // R2
  AST_TAKE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(last_clk_i)); // R3
  AST_EXT_MEANS_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack_o |-> (take_o && vec_o == '0)); // R4
  AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ien_w); // R5
  AST_MASKABLE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o != VEC_NMI) |-> $past(ien_w)); // R5
endmodule

bind prio_irq_ctl prio_irq_ctl_chk #(.VW(VW), .VEC_NMI(VEC_NMI)) u_chk (
  .clk(clk), .rst_n(rst_n), .last_clk_i(last_clk_i), .nmi_i(nmi_i),
  .nmi_pend_w(nmi_pend_w), .ien_w(ien_w), .win_w(win_w),
  .take_o(take_o), .ext_ack_o(ext_ack_o), .vec_o(vec_o)
);

// File: tb/prio_irq_ctl_test.sv
`timescale 1ns/1ps
module prio_irq_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, gen_req_i = 0;
  logic last_clk_i = 0, op_vld_i = 0, msk_we_i = 0;
  logic [7:0] op_i = 8'h00, msk_d_i = 8'h00;
  logic take_o, ext_ack_o;
  logic [15:0] vec_o;
  logic [7:0] stat_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  prio_irq_ctl uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rst75_i(rst75_i),
    .rst65_i(rst65_i), .rst55_i(rst55_i), .gen_req_i(gen_req_i),
    .last_clk_i(last_clk_i), .op_vld_i(op_vld_i), .op_i(op_i),
    .msk_we_i(msk_we_i), .msk_d_i(msk_d_i),
    .take_o(take_o), .ext_ack_o(ext_ack_o), .vec_o(vec_o), .stat_o(stat_o)
  );

  // behavioural reference
  bit m_ien, m_la, m_pa, m_arm, m_np, e_take, e_ext;
  bit [2:0] m_msk;
  int e_vec;
  int pick;

  function automatic int vec_for(input int who);
    case (who)
      1: return 36;   // 0x24
      2: return 60;   // 0x3C
      3: return 52;   // 0x34
      4: return 44;   // 0x2C
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ien = 0; m_msk = 3'b111; m_la = 0; m_pa = 0; m_arm = 0; m_np = 0;
      e_take = 0; e_ext = 0; e_vec = 0;
    end else begin
      pick = 0;
      if (m_arm && nmi_i) pick = 1;
      else if (m_ien && m_la && !m_msk[2]) pick = 2;
      else if (m_ien && rst65_i && !m_msk[1]) pick = 3;
      else if (m_ien && rst55_i && !m_msk[0]) pick = 4;
      else if (m_ien && gen_req_i) pick = 5;
      if (!last_clk_i) pick = 0;
      e_take = (pick != 0);
      e_ext = (pick == 5);
      e_vec = vec_for(pick);
      if (!nmi_i) m_arm = 0;
      else if (!m_np) m_arm = 1;
      else if (pick == 1) m_arm = 0;
      if (pick == 2 || (msk_we_i && msk_d_i[4])) m_la = 0;
      if (rst75_i && !m_pa) m_la = 1;
      if (pick != 0) m_ien = 0;
      else if (op_vld_i && op_i == 8'hFB) m_ien = 1;
      else if (op_vld_i && op_i == 8'hF3) m_ien = 0;
      if (msk_we_i && msk_d_i[3]) m_msk = msk_d_i[2:0];
      m_np = nmi_i; m_pa = rst75_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (take_o !== e_take || vec_o !== e_vec[15:0]) begin
        errors++;
        $display("FAIL R1 model: take/vec %0b/%h expected %0b/%h", take_o, vec_o, e_take, e_vec[15:0]);
      end
      checks++;
      if (ext_ack_o !== e_ext) begin
        errors++;
        $display("FAIL R4 model: ext %0b expected %0b", ext_ack_o, e_ext);
      end
      checks++;
      if (stat_o !== {1'b0, m_la, rst65_i, rst55_i, m_ien, m_msk}) begin
        errors++;
        $display("FAIL R10 model: stat %h expected %h", stat_o, {1'b0, m_la, rst65_i, rst55_i, m_ien, m_msk});
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_take(input string tag, input bit t, input int v, input bit x);
    chk(tag, {take_o, ext_ack_o, vec_o}, {t, x, v[15:0]});
  endtask

  task automatic do_sample();
    last_clk_i = 1; tick(); last_clk_i = 0;
  endtask

  task automatic opc(input logic [7:0] c);
    op_vld_i = 1; op_i = c; tick(); op_vld_i = 0;
  endtask

  task automatic mskw(input logic [7:0] d);
    msk_we_i = 1; msk_d_i = d; tick(); msk_we_i = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R10 reset status", stat_o, 8'h07);
    chk("R5 reset take", take_o, 0);

    nmi_i = 1; tick();
    do_sample(); expect_take("R2 nmi while disabled+masked", 1, 16'h0024, 0);
    tick(); chk("R3 single pulse", take_o, 0);
    do_sample(); expect_take("R9 no re-take without rise", 0, 0, 0);
    nmi_i = 0; tick(); nmi_i = 1;
    do_sample(); expect_take("R9 rise on sample edge too late", 0, 0, 0);
    do_sample(); expect_take("R9 rise seen then sampled", 1, 16'h0024, 0);
    nmi_i = 1; tick(); nmi_i = 0; tick();
    do_sample(); expect_take("R9 fell before sample", 0, 0, 0);
    nmi_i = 0;

    opc(8'hFB); chk("R5 enable opcode", stat_o[3], 1);
    opc(8'hF3); chk("R5 disable opcode", stat_o[3], 0);
    opc(8'hFB);

    rst65_i = 1; rst55_i = 1; tick();
    chk("R10 level bits", stat_o[5:4], 2'b11);
    do_sample(); expect_take("R6 masked lines", 0, 0, 0);
    repeat (3) begin tick(); chk("R3 no sample no take", take_o, 0); end

    mskw(8'h08); chk("R6 masks loaded", stat_o[2:0], 3'b000);
    gen_req_i = 1;
    do_sample(); expect_take("R1 R8 B over C and general", 1, 16'h0034, 0);
    chk("R5 cleared on accept", stat_o[3], 0);
    do_sample(); expect_take("R5 disabled blocks", 0, 0, 0);
    opc(8'hFB); rst65_i = 0;
    do_sample(); expect_take("R8 C level", 1, 16'h002C, 0);
    opc(8'hFB); rst55_i = 0;
    do_sample(); expect_take("R4 general request", 1, 0, 1);

    gen_req_i = 0; rst75_i = 1; tick(); rst75_i = 0; tick();
    chk("R7 latch set", stat_o[6], 1);
    opc(8'hFB); gen_req_i = 1;
    do_sample(); expect_take("R1 A over general", 1, 16'h003C, 0);
    chk("R7 latch cleared by accept", stat_o[6], 0);

    mskw(8'h0C); chk("R6 A masked", stat_o[2:0], 3'b100);
    rst75_i = 1; tick(); rst75_i = 0; tick();
    chk("R7 latch sets while masked", stat_o[6], 1);
    opc(8'hFB);
    do_sample(); expect_take("R6 masked A skipped", 1, 0, 1);
    mskw(8'h10);
    chk("R7 clear via mask strobe", stat_o[6], 0);
    chk("R6 no load without bit3", stat_o[2:0], 3'b100);

    gen_req_i = 0; mskw(8'h08);
    rst75_i = 1; tick(); opc(8'hFB);
    do_sample(); expect_take("R7 A taken", 1, 16'h003C, 0);
    opc(8'hFB);
    do_sample(); expect_take("R7 held level no repeat", 0, 0, 0);
    rst75_i = 0;

    rst55_i = 1; op_vld_i = 1; op_i = 8'hFB; last_clk_i = 1; tick();
    op_vld_i = 0; last_clk_i = 0;
    expect_take("R5 accept with enable opcode", 1, 16'h002C, 0);
    chk("R5 accept wins over enable", stat_o[3], 0);
    rst55_i = 0;

    nmi_i = 1; rst75_i = 1; tick(); rst75_i = 0; opc(8'hFB);
    do_sample(); expect_take("R1 nmi over A", 1, 16'h0024, 0);
    opc(8'hFB);
    do_sample(); expect_take("R1 A after nmi", 1, 16'h003C, 0);
    nmi_i = 0;

    mskw(8'h0A); rst65_i = 1; rst55_i = 1; opc(8'hFB);
    do_sample(); expect_take("R6 B masked C taken", 1, 16'h002C, 0);
    rst65_i = 0; rst55_i = 0;
    repeat (2) tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule